// File: doc/BRIEF.md
# Edge-Triggered Capture Timer

This block is a down-counter that measures the time between edges on one external input. The counter steps down by one on each cycle where the count-tick strobe is high. When the input shows an edge of the selected polarity, the current count is copied into a capture register that software can read. An optional preset reloads the counter to all ones on every capture, so each captured value gives the interval since the previous edge, expressed as all-ones minus the captured count.

The block has two event sources, a capture and a counter underflow. Each has a pending flag that is cleared by a strobe and an enable that routes the flag onto a shared interrupt line.

Edge detection uses a three-state machine: `ST_INIT`, `ST_LOW` and `ST_HIGH`. After reset the machine is in `ST_INIT`, and on the first sampled level it moves to `ST_LOW` or `ST_HIGH` without reporting an edge. From then on it moves `ST_LOW→ST_HIGH` on a high sample (a rising edge) and `ST_HIGH→ST_LOW` on a low sample (a falling edge). Samples that match the current level leave the state unchanged.

A qualifying edge is registered as an event. The event takes effect one clock later.

Top module: `edge_capture_timer`

## Requirements
- R1: After reset, `capture_o` is 0, both pending flags are 0, `irq_o` is 0 and the internal counter holds 0xFFFF.
- R2: In a cycle with `tick_i` high and no preset, the counter decrements by one. From 0x0000 it wraps to 0xFFFF. Without a tick it holds.
- R3: An edge is sampled at clock edge k: with `edge_rise_i`=1 it is input 0 then 1, and with `edge_rise_i`=0 it is input 1 then 0. At clock edge k+1, `capture_o` loads the counter value held just before edge k+1.
- R4: An edge of the opposite polarity, or a level held unchanged, leaves `capture_o` and `cap_pend_o` unchanged.
- R5: The first input level sampled after reset never counts as an edge.
- R6: With `preset_en_i`=1, a capture loads the counter with 0xFFFF instead of applying that cycle's tick. That cycle produces no underflow, and the captured value is the count before the tick.
- R7: A capture sets `cap_pend_o`. `cap_clr_i` clears it, but a capture in the same cycle as a clear leaves it set.
- R8: A tick taken from 0x0000 sets `unf_pend_o`. `unf_clr_i` clears it, and an underflow in the same cycle as a clear keeps it set.
- R9: `irq_o` = (`cap_pend_o` & `cap_ie_i`) | (`unf_pend_o` & `unf_ie_i`), combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count-enable strobe |
| cap_in_i | input | 1 | Synchronized capture input |
| edge_rise_i | input | 1 | 1 selects rising edges, 0 selects falling edges |
| preset_en_i | input | 1 | Reload counter to all ones on capture |
| cap_ie_i | input | 1 | Capture interrupt enable |
| unf_ie_i | input | 1 | Underflow interrupt enable |
| cap_clr_i | input | 1 | Clear strobe for capture pending flag |
| unf_clr_i | input | 1 | Clear strobe for underflow pending flag |
| capture_o | output | 16 | Capture register value |
| cap_pend_o | output | 1 | Capture pending flag |
| unf_pend_o | output | 1 | Underflow pending flag |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `cap_in_i` is already synchronous to `clk` and holds each level for at least one full cycle. They also assume the polarity select does not change between the sample that sees an edge and the cycle after it. The bench drives every input only at falling clock edges, so each level is held for a whole cycle. It changes the polarity and preset settings only between phases, while the capture input is held steady for several cycles. One long phase keeps the tick high continuously so that the counter reaches underflow. The other phases randomize ticks, edges and clears, and at every clock they compare against a behavioural model.

// File: rtl/cap_tmr_pkg.sv
package cap_tmr_pkg;
    typedef enum logic [1:0] {
        ST_INIT = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } lvl_state_e;

    localparam int unsigned NUM_FLAGS = 2;
    localparam int unsigned FLAG_CAP  = 0;
    localparam int unsigned FLAG_UNF  = 1;
endpackage

// File: rtl/cap_edge_fsm.sv
module cap_edge_fsm
    import cap_tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    input  logic rise_sel_i,
    output logic evt_o
);
    lvl_state_e state_q, state_d;
    logic       qual_edge;

    always_comb begin
        state_d   = state_q;
        qual_edge = 1'b0;
        unique case (state_q)
            ST_INIT: state_d = sig_i ? ST_HIGH : ST_LOW;
            ST_LOW: begin
                if (sig_i) begin
                    state_d   = ST_HIGH;
                    qual_edge = rise_sel_i;
                end
            end
            ST_HIGH: begin
                if (!sig_i) begin
                    state_d   = ST_LOW;
                    qual_edge = !rise_sel_i;
                end
            end
            default: state_d = ST_INIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_o <= 1'b0;
        else        evt_o <= qual_edge;
    end

    // R5: leaving the initial state never yields an event
    a_r5_init_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT) |=> !evt_o);

    // R3/R4: an event matches the selected polarity of the sampled level
    a_r4_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> ($past(rise_sel_i) ? $past(sig_i) : !$past(sig_i)));
endmodule

// File: rtl/cap_down_counter.sv
module cap_down_counter #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             preset_i,
    output logic [WIDTH-1:0] count_o,
    output logic             unf_o
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ZERO     = '0;

    always_comb begin
        unf_o = tick_i && !preset_i && (count_o == ZERO);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        count_o <= ALL_ONES;
        else if (preset_i) count_o <= ALL_ONES;
        else if (tick_i)   count_o <= count_o - 1'b1;
    end

    // R2: a tick without preset steps the count down by one (wrapping)
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !preset_i) |=> (count_o == $past(count_o) - 1'b1));

    // R2: no tick and no preset holds the count
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !preset_i) |=> $stable(count_o));

    // R6: preset forces all ones whatever the tick
    a_r6_preset: assert property (@(posedge clk) disable iff (!rst_n)
        preset_i |=> (count_o == ALL_ONES));
endmodule

// File: rtl/cap_pend_flag.sv
module cap_pend_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pend_o <= 1'b0;
        else if (set_i) pend_o <= 1'b1;
        else if (clr_i) pend_o <= 1'b0;
    end

    // R7/R8: a set in the same cycle as a clear wins
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_o);

    // R7/R8: a lone clear drops the flag
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !pend_o);
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
    import cap_tmr_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cap_in_i,
    input  logic             edge_rise_i,
    input  logic             preset_en_i,
    input  logic             cap_ie_i,
    input  logic             unf_ie_i,
    input  logic             cap_clr_i,
    input  logic             unf_clr_i,
    output logic [WIDTH-1:0] capture_o,
    output logic             cap_pend_o,
    output logic             unf_pend_o,
    output logic             irq_o
);
    logic             cap_evt;
    logic             unf_evt;
    logic [WIDTH-1:0] count;
    logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q, flag_ie;

    cap_edge_fsm u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .sig_i      (cap_in_i),
        .rise_sel_i (edge_rise_i),
        .evt_o      (cap_evt)
    );

    cap_down_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .preset_i (cap_evt && preset_en_i),
        .count_o  (count),
        .unf_o    (unf_evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       capture_o <= '0;
        else if (cap_evt) capture_o <= count;
    end

    always_comb begin
        flag_set[FLAG_CAP] = cap_evt;
        flag_set[FLAG_UNF] = unf_evt;
        flag_clr[FLAG_CAP] = cap_clr_i;
        flag_clr[FLAG_UNF] = unf_clr_i;
        flag_ie[FLAG_CAP]  = cap_ie_i;
        flag_ie[FLAG_UNF]  = unf_ie_i;
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        cap_pend_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (flag_set[g]),
            .clr_i  (flag_clr[g]),
            .pend_o (flag_q[g])
        );
    end

    always_comb begin
        cap_pend_o = flag_q[FLAG_CAP];
        unf_pend_o = flag_q[FLAG_UNF];
        irq_o      = |(flag_q & flag_ie);
    end

    // R3: an event loads the count seen before that edge
    a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (capture_o == $past(count)));

    // R4: without an event the capture register holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_evt |=> $stable(capture_o));

    // R6: preset with a tick never reports underflow
    a_r6_no_unf: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt && preset_en_i) |-> !unf_evt);
endmodule

// File: tb/test_edge_capture_timer.sv
module test_edge_capture_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, cap_in = 1'b0, rise = 1'b1, preset = 1'b0;
    logic        cie = 1'b0, uie = 1'b0, cclr = 1'b0, uclr = 1'b0;
    logic [15:0] capture;
    logic        cpend, upend, irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // behavioural reference state
    int m_count, m_cap;
    bit m_pc, m_pu, m_evt, m_lvl, m_init;

    always #4 clk = ~clk;

    edge_capture_timer i_edge_capture_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .cap_in_i(cap_in),
        .edge_rise_i(rise), .preset_en_i(preset), .cap_ie_i(cie),
        .unf_ie_i(uie), .cap_clr_i(cclr), .unf_clr_i(uclr),
        .capture_o(capture), .cap_pend_o(cpend), .unf_pend_o(upend),
        .irq_o(irq)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_count = 65535; m_cap = 0; m_pc = 0; m_pu = 0;
            m_evt = 0; m_lvl = 0; m_init = 1;
        end else begin
            bit ev_now, unf;
            ev_now = !m_init && (rise ? (!m_lvl && cap_in) : (m_lvl && !cap_in));
            unf = 0;
            if (m_evt) m_cap = m_count;
            if (m_evt && preset) m_count = 65535;             // R6
            else if (tick) begin                               // R2
                if (m_count == 0) begin m_count = 65535; unf = 1; end
                else m_count = m_count - 1;
            end
            m_pc = m_evt ? 1 : (cclr ? 0 : m_pc);              // R7
            m_pu = unf ? 1 : (uclr ? 0 : m_pu);                // R8
            m_evt = ev_now;                                    // R3 R4 R5
            m_lvl = cap_in;
            m_init = 0;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R3/R4/R6 capture", int'(capture), m_cap);
        chk("R7 cap_pend", int'(cpend), int'(m_pc));
        chk("R8 unf_pend", int'(upend), int'(m_pu));
        chk("R9 irq", int'(irq), int'((m_pc && cie) || (m_pu && uie)));
    endtask

    task automatic run(int cycles, int tick_pct, int edge_pct, int clr_pct);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            compare_all();
            tick = ($urandom_range(99) < tick_pct);
            if ($urandom_range(99) < edge_pct) cap_in = ~cap_in;
            cclr = ($urandom_range(99) < clr_pct);
            uclr = ($urandom_range(99) < clr_pct);
            cie  = $urandom_range(1);
            uie  = $urandom_range(1);
        end
        // settle the input before a configuration change
        cclr = 0; uclr = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            compare_all();
        end
    endtask

    initial begin
        cap_in = 1'b1;            // R5: high level at reset must not capture
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 capture", int'(capture), 0);
        chk("R1 cap_pend", int'(cpend), 0);
        chk("R1 unf_pend", int'(upend), 0);
        chk("R1 irq", int'(irq), 0);
        compare_all();
        // R1 R2: first captures reveal FFFF start and decrement
        rise = 1; preset = 0;
        run(300, 50, 10, 5);
        rise = 0;                 // R4: opposite polarity exercised
        run(300, 60, 15, 5);
        // R2 R8: continuous ticking to wrap through zero
        rise = 1; preset = 0;
        run(70000, 100, 1, 0);
        run(400, 80, 10, 10);
        // R6: preset on capture, ticks racing it
        preset = 1; rise = 0;
        run(4000, 90, 20, 8);
        preset = 1; rise = 1;
        run(4000, 100, 30, 30);
        // R7 R9: heavy clear traffic with enables
        preset = 0;
        run(2000, 70, 25, 40);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule